// File: doc/BRIEF.md
# Hash Engine Input/Output Buffer Controller

This block sits between a host register port and a SHA-2 compression core. It holds one message block in 32-bit data-in words and a bank of 32-bit digest words. A small set of flags lets software pace the transfer. A ready flag tells the host when it may fill the data-in words. A data-available write hands the buffered block to the core, with an optional request for final padding. A get-digest write asks the core to place its chaining value in the digest bank. An output-full flag then marks that bank as holding fresh values, and the host releases it by writing 1 to that flag.

The algorithm select sets how many data-in words form one block and how many digest words are exposed. The digest bank is also writable while the engine is idle. A saved intermediate digest can therefore be loaded back and driven to the core, so that a hash can continue with more blocks. The core receives the whole block and the whole digest bank as flat buses. Word i of each bus sits at bits [32*i +: 32].

Top module: `hio_iobuf_ctrl`

## Requirements
- R1: After reset, `rdy_in` is 1 and `avail`, `out_full`, `core_start` and `core_dig_req` are 0. All data-in words and digest words read as zero.
- R2: `alg_sel` selects the algorithm with the encoding 0 = SHA-224, 1 = SHA-256, 2 = SHA-384, 3 = SHA-512. The block size is 16 words for codes 0 and 1 and 32 words for codes 2 and 3. The digest size is 7, 8, 12 and 16 words for codes 0 to 3 in that order.
- R3: A data-in write is stored only if `rdy_in` is 1 and `din_idx` is below the block size. Any other data-in write leaves `core_block` unchanged. Words of `core_block` at or above the block size are driven as zero.
- R4: A `ctl_set_avail` pulse while `avail` is 0 raises `avail` at the next edge and latches `ctl_pad` onto `core_pad`. While `avail` is 1, `rdy_in` is 0. `core_start` is a single-cycle pulse, issued in the first cycle in which `avail` is 1, the block has not yet been started, and neither `out_full` nor a pending digest request is set.
- R5: A `core_done` pulse for a started block clears `avail` and zeroes every data-in word at that edge. `rdy_in` is 1 in the following cycle.
- R6: While `out_full` is 1, `rdy_in` is 0 and `core_start` stays 0. A data-available request made in that time is held and starts the core once `out_full` clears.
- R7: A `ctl_get_digest` pulse while `avail`, `out_full` and `core_dig_req` are all 0 raises `core_dig_req`, which stays high until `core_dig_vld`. At that edge the digest bank loads the words of `core_dig_in` below the digest size, zeroes the rest, and `out_full` rises.
- R8: Writing 1 to `ctl_clr_full` clears `out_full` at the next edge, unless a digest capture happens at the same edge.
- R9: A digest write is stored only while `avail` and `core_dig_req` are both 0 and `dig_idx` is below the digest size. `core_chain` always presents the digest bank.
- R10: `dig_rdata` returns the digest word at `dig_ridx` when that index is below the digest size, and zero otherwise.
- R11: A `ctl_get_digest` pulse while `avail`, `out_full` or `core_dig_req` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alg_sel | input | 2 | Algorithm code |
| din_we | input | 1 | Data-in word write strobe |
| din_idx | input | 5 | Data-in word index |
| din_wdata | input | 32 | Data-in write value |
| dig_we | input | 1 | Digest word write strobe |
| dig_idx | input | 4 | Digest word write index |
| dig_wdata | input | 32 | Digest write value |
| dig_ridx | input | 4 | Digest word read index |
| dig_rdata | output | 32 | Digest read value |
| ctl_set_avail | input | 1 | Host writes 1 to data-available |
| ctl_pad | input | 1 | Pad request sampled with data-available |
| ctl_get_digest | input | 1 | Host writes 1 to get-digest |
| ctl_clr_full | input | 1 | Host writes 1 to output-full (clear) |
| rdy_in | output | 1 | Data-in words may be written |
| avail | output | 1 | Block handed to the core, not yet consumed |
| out_full | output | 1 | Digest bank holds fresh values |
| core_start | output | 1 | Start pulse to the core |
| core_pad | output | 1 | Apply final padding to this block |
| core_block | output | 1024 | Buffered block, word i at [32*i +: 32] |
| core_chain | output | 512 | Digest bank, word i at [32*i +: 32] |
| core_done | input | 1 | Core finished the started block |
| core_dig_req | output | 1 | Request for the core to output its digest |
| core_dig_vld | input | 1 | Core digest valid on core_dig_in |
| core_dig_in | input | 512 | Digest from the core |

## Verification
The bound checker watches the flag interplay on every cycle. It checks that `rdy_in` is low while a block is pending and while output-full is set. It checks that a start is a lone pulse and never occurs while output-full is set. It also checks that the block bus is frozen while the block is pending, that the buffer is empty and ready after consumption, that output-full rises only on a capture and falls after a clear, and that out-of-range digest reads return zero. Only the bench's scenarios can show the rest: the exact word counts per algorithm, a held data-available request that starts once output-full clears, a restored digest reaching the core, and ignored writes and digest requests.

// File: rtl/hio_pkg.sv
package hio_pkg;

  typedef enum logic [1:0] {
    ALG_224 = 2'd0,
    ALG_256 = 2'd1,
    ALG_384 = 2'd2,
    ALG_512 = 2'd3
  } hio_alg_e;

  // Words in one message block: the long algorithms use the full buffer.
  function automatic int unsigned blk_words(hio_alg_e a, int unsigned blk_max);
    return (a == ALG_384 || a == ALG_512) ? blk_max : blk_max / 2;
  endfunction

  // Digest words exposed to the host, scaled from the widest algorithm.
  function automatic int unsigned dig_words(hio_alg_e a, int unsigned dig_max);
    case (a)
      ALG_224: return (dig_max * 7) / 16;
      ALG_256: return dig_max / 2;
      ALG_384: return (dig_max * 3) / 4;
      default: return dig_max;
    endcase
  endfunction

endpackage

// File: rtl/hio_flow_ctl.sv
module hio_flow_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_avail,
  input  logic pad_in,
  input  logic get_dig,
  input  logic clr_full,
  input  logic core_done,
  input  logic dig_vld,
  output logic rdy,
  output logic avail,
  output logic full,
  output logic busy,
  output logic start,
  output logic pad,
  output logic capture,
  output logic consume,
  output logic dig_idle
);

  logic avail_q, started_q, full_q, busy_q, pad_q;
  logic take_avail, take_dig;

  assign start      = avail_q & ~started_q & ~full_q & ~busy_q;
  assign consume    = core_done & started_q;
  assign capture    = busy_q & dig_vld;
  assign take_avail = set_avail & ~avail_q;
  assign take_dig   = get_dig & ~avail_q & ~full_q & ~busy_q;

  assign rdy      = ~avail_q & ~full_q & ~busy_q;
  assign dig_idle = ~avail_q & ~busy_q;
  assign avail    = avail_q;
  assign full     = full_q;
  assign busy     = busy_q;
  assign pad      = pad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q   <= 1'b0;
      started_q <= 1'b0;
      full_q    <= 1'b0;
      busy_q    <= 1'b0;
      pad_q     <= 1'b0;
    end else begin
      if (consume)         avail_q <= 1'b0;
      else if (take_avail) avail_q <= 1'b1;

      if (consume)    started_q <= 1'b0;
      else if (start) started_q <= 1'b1;

      if (take_avail) pad_q <= pad_in;

      if (capture)       busy_q <= 1'b0;
      else if (take_dig) busy_q <= 1'b1;

      if (capture)       full_q <= 1'b1;
      else if (clr_full) full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hio_din_buf.sv
module hio_din_buf #(
  parameter int W       = 32,
  parameter int BLK_MAX = 32,
  localparam int IW     = $clog2(BLK_MAX),
  localparam int CW     = IW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ok,
  input  logic [IW-1:0]         idx,
  input  logic [W-1:0]          wdata,
  input  logic                  clr,
  input  logic [CW-1:0]         bw,
  output logic [W*BLK_MAX-1:0]  block
);

  for (genvar i = 0; i < BLK_MAX; i++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             word_q <= '0;
      else if (clr)                           word_q <= '0;
      else if (wr_ok && idx == IW'(i))        word_q <= wdata;
    end
    assign block[W*i +: W] = (CW'(i) < bw) ? word_q : '0;
  end

endmodule

// File: rtl/hio_dig_bank.sv
module hio_dig_bank #(
  parameter int W       = 32,
  parameter int DIG_MAX = 16,
  localparam int IW     = $clog2(DIG_MAX),
  localparam int CW     = IW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ok,
  input  logic [IW-1:0]         idx,
  input  logic [W-1:0]          wdata,
  input  logic                  cap,
  input  logic [W*DIG_MAX-1:0]  cap_data,
  input  logic [CW-1:0]         dw,
  input  logic [IW-1:0]         ridx,
  output logic [W-1:0]          rdata,
  output logic [W*DIG_MAX-1:0]  chain
);

  logic [W-1:0] words [DIG_MAX];

  for (genvar i = 0; i < DIG_MAX; i++) begin : g_word
    logic in_range;
    assign in_range = CW'(i) < dw;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       words[i] <= '0;
      else if (cap)                     words[i] <= in_range ? cap_data[W*i +: W] : '0;
      else if (wr_ok && idx == IW'(i))  words[i] <= wdata;
    end
    assign chain[W*i +: W] = words[i];
  end

  assign rdata = ({1'b0, ridx} < dw) ? words[ridx] : '0;

endmodule

// File: rtl/hio_iobuf_ctrl.sv
module hio_iobuf_ctrl
  import hio_pkg::*;
#(
  parameter int W       = 32,
  parameter int BLK_MAX = 32,
  parameter int DIG_MAX = 16,
  localparam int BIW    = $clog2(BLK_MAX),
  localparam int DIW    = $clog2(DIG_MAX),
  localparam int BCW    = BIW + 1,
  localparam int DCW    = DIW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            alg_sel,
  input  logic                  din_we,
  input  logic [BIW-1:0]        din_idx,
  input  logic [W-1:0]          din_wdata,
  input  logic                  dig_we,
  input  logic [DIW-1:0]        dig_idx,
  input  logic [W-1:0]          dig_wdata,
  input  logic [DIW-1:0]        dig_ridx,
  output logic [W-1:0]          dig_rdata,
  input  logic                  ctl_set_avail,
  input  logic                  ctl_pad,
  input  logic                  ctl_get_digest,
  input  logic                  ctl_clr_full,
  output logic                  rdy_in,
  output logic                  avail,
  output logic                  out_full,
  output logic                  core_start,
  output logic                  core_pad,
  output logic [W*BLK_MAX-1:0]  core_block,
  output logic [W*DIG_MAX-1:0]  core_chain,
  input  logic                  core_done,
  output logic                  core_dig_req,
  input  logic                  core_dig_vld,
  input  logic [W*DIG_MAX-1:0]  core_dig_in
);

  hio_alg_e       alg;
  logic [BCW-1:0] bw;
  logic [DCW-1:0] dw;

  assign alg = hio_alg_e'(alg_sel);
  assign bw  = BCW'(blk_words(alg, BLK_MAX));
  assign dw  = DCW'(dig_words(alg, DIG_MAX));

  // Named internal events, also observed by the bound checker.
  logic din_accept, dig_wr_accept, dig_capture, blk_consume, dig_idle;

  hio_flow_ctl u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_avail (ctl_set_avail),
    .pad_in    (ctl_pad),
    .get_dig   (ctl_get_digest),
    .clr_full  (ctl_clr_full),
    .core_done (core_done),
    .dig_vld   (core_dig_vld),
    .rdy       (rdy_in),
    .avail     (avail),
    .full      (out_full),
    .busy      (core_dig_req),
    .start     (core_start),
    .pad       (core_pad),
    .capture   (dig_capture),
    .consume   (blk_consume),
    .dig_idle  (dig_idle)
  );

  assign din_accept    = din_we & rdy_in & ({1'b0, din_idx} < bw);
  assign dig_wr_accept = dig_we & dig_idle & ({1'b0, dig_idx} < dw);

  hio_din_buf #(.W(W), .BLK_MAX(BLK_MAX)) u_din (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (din_accept),
    .idx   (din_idx),
    .wdata (din_wdata),
    .clr   (blk_consume),
    .bw    (bw),
    .block (core_block)
  );

  hio_dig_bank #(.W(W), .DIG_MAX(DIG_MAX)) u_dig (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (dig_wr_accept),
    .idx      (dig_idx),
    .wdata    (dig_wdata),
    .cap      (dig_capture),
    .cap_data (core_dig_in),
    .dw       (dw),
    .ridx     (dig_ridx),
    .rdata    (dig_rdata),
    .chain    (core_chain)
  );

endmodule

// File: rtl/hio_chk.sv
module hio_chk #(
  parameter int W       = 32,
  parameter int BLK_MAX = 32,
  parameter int DIG_MAX = 16,
  localparam int DIW    = $clog2(DIG_MAX)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            alg_sel,
  input logic [DIW-1:0]        dig_ridx,
  input logic [W-1:0]          dig_rdata,
  input logic                  ctl_clr_full,
  input logic                  rdy_in,
  input logic                  avail,
  input logic                  out_full,
  input logic                  core_start,
  input logic [W*BLK_MAX-1:0]  core_block,
  input logic                  dig_capture,
  input logic                  blk_consume
);

  // Digest size restated from the requirement table, not from the package.
  int unsigned dsz;
  always_comb begin
    unique case (alg_sel)
      2'd0:    dsz = 7;
      2'd1:    dsz = 8;
      2'd2:    dsz = 12;
      default: dsz = 16;
    endcase
  end

  // R3
  blk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail && !blk_consume |=> $stable(core_block));

  // R4
  rdy_low_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> !rdy_in);

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R5
  ready_after_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_consume |=> rdy_in && !avail && core_block == '0);

  // R6
  no_start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !core_start && !rdy_in);

  // R7
  full_from_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_full) |-> $past(dig_capture));

  // R8
  full_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr_full && out_full && !dig_capture |=> !out_full);

  // R10
  dig_read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dig_ridx) >= dsz) |-> dig_rdata == '0);

endmodule

bind hio_iobuf_ctrl hio_chk #(.W(W), .BLK_MAX(BLK_MAX), .DIG_MAX(DIG_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alg_sel      (alg_sel),
  .dig_ridx     (dig_ridx),
  .dig_rdata    (dig_rdata),
  .ctl_clr_full (ctl_clr_full),
  .rdy_in       (rdy_in),
  .avail        (avail),
  .out_full     (out_full),
  .core_start   (core_start),
  .core_block   (core_block),
  .dig_capture  (dig_capture),
  .blk_consume  (blk_consume)
);

// File: tb/tb_hio_iobuf_ctrl.sv
module tb_hio_iobuf_ctrl;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    alg_sel = 2'd1;
  logic          din_we = 0;
  logic [4:0]    din_idx = 0;
  logic [31:0]   din_wdata = 0;
  logic          dig_we = 0;
  logic [3:0]    dig_idx = 0;
  logic [31:0]   dig_wdata = 0;
  logic [3:0]    dig_ridx = 0;
  logic [31:0]   dig_rdata;
  logic          ctl_set_avail = 0, ctl_pad = 0, ctl_get_digest = 0, ctl_clr_full = 0;
  logic          rdy_in, avail, out_full, core_start, core_pad, core_dig_req;
  logic [1023:0] core_block;
  logic [511:0]  core_chain;
  logic          core_done = 0, core_dig_vld = 0;
  logic [511:0]  core_dig_in = '0;

  int errors = 0, checks = 0, cycles = 0;
  bit started_seen = 0;

  always #10 clk = ~clk;

  hio_iobuf_ctrl dut (.*);

  // ---------------- reference model ----------------
  logic [31:0] m_din [32];
  logic [31:0] m_dig [16];
  bit m_avail, m_started, m_full, m_busy, m_pad;

  function automatic int bsz(logic [1:0] a); return a[1] ? 32 : 16; endfunction
  function automatic int dsz(logic [1:0] a);
    int t[4] = '{7, 8, 12, 16};
    return t[a];
  endfunction
  function automatic bit m_rdy(); return !m_avail && !m_full && !m_busy; endfunction
  function automatic bit m_start(); return m_avail && !m_started && !m_full && !m_busy; endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_din[i]) m_din[i] = '0;
      foreach (m_dig[i]) m_dig[i] = '0;
      {m_avail, m_started, m_full, m_busy, m_pad} = '0;
    end else begin
      bit rdy0, st0, av0, bz0, fl0;
      rdy0 = m_rdy(); st0 = m_start(); av0 = m_avail; bz0 = m_busy; fl0 = m_full;
      if (din_we && rdy0 && din_idx < bsz(alg_sel)) m_din[din_idx] = din_wdata;
      if (dig_we && !av0 && !bz0 && dig_idx < dsz(alg_sel)) m_dig[dig_idx] = dig_wdata;
      if (core_done && m_started) begin
        m_avail = 0; m_started = 0;
        foreach (m_din[i]) m_din[i] = '0;
      end else if (st0) m_started = 1;
      if (ctl_set_avail && !av0) begin m_avail = 1; m_pad = ctl_pad; end
      if (bz0 && core_dig_vld) begin
        for (int i = 0; i < 16; i++) m_dig[i] = (i < dsz(alg_sel)) ? core_dig_in[32*i +: 32] : '0;
        m_full = 1; m_busy = 0;
      end else begin
        if (ctl_clr_full) m_full = 0;
        if (ctl_get_digest && !av0 && !fl0 && !bz0) m_busy = 1;
      end
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      logic [1023:0] eb;
      logic [511:0]  ec;
      cycles++;
      if (core_start) started_seen = 1;
      for (int i = 0; i < 32; i++) eb[32*i +: 32] = (i < bsz(alg_sel)) ? m_din[i] : '0;
      for (int i = 0; i < 16; i++) ec[32*i +: 32] = m_dig[i];
      chk("R4 rdy_in", rdy_in, m_rdy());
      chk("R5 avail", avail, m_avail);
      chk("R8 out_full", out_full, m_full);
      chk("R6 core_start", core_start, m_start());
      chk("R4 core_pad", core_pad, m_pad);
      chk("R7 core_dig_req", core_dig_req, m_busy);
      chk("R3 core_block", 64'(core_block != eb), 64'd0);
      chk("R9 core_chain", 64'(core_chain != ec), 64'd0);
      chk("R10 dig_rdata", dig_rdata, (dig_ridx < dsz(alg_sel)) ? m_dig[dig_ridx] : 32'd0);
    end
  end

  // ---------------- behavioural core ----------------
  int dn = 0, dc = 0;
  always @(negedge clk) begin
    core_done = 0; core_dig_vld = 0;
    if (core_start) dn = 1;
    else if (dn > 0) begin dn++; if (dn == 4) begin core_done = 1; dn = 0; end end
    if (core_dig_req) begin dc++; if (dc == 3) begin core_dig_vld = 1; dc = 0; end end
    else dc = 0;
  end

  // ---------------- host tasks ----------------
  task automatic tick(int n = 1); repeat (n) @(negedge clk); endtask

  task automatic wr_din(int idx, logic [31:0] v);
    @(negedge clk); din_we = 1; din_idx = 5'(idx); din_wdata = v;
    @(negedge clk); din_we = 0;
  endtask
  task automatic wr_dig(int idx, logic [31:0] v);
    @(negedge clk); dig_we = 1; dig_idx = 4'(idx); dig_wdata = v;
    @(negedge clk); dig_we = 0;
  endtask
  task automatic pulse_avail(bit pad);
    @(negedge clk); ctl_set_avail = 1; ctl_pad = pad;
    @(negedge clk); ctl_set_avail = 0; ctl_pad = 0;
  endtask
  task automatic pulse_get();
    @(negedge clk); ctl_get_digest = 1; @(negedge clk); ctl_get_digest = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); ctl_clr_full = 1; @(negedge clk); ctl_clr_full = 0;
  endtask
  task automatic wait_idle(); while (avail || core_dig_req) @(negedge clk); endtask

  task automatic count_digest(string tag, int exp);
    int n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); dig_ridx = 4'(i); #1;
      if (dig_rdata != 0) n++;
    end
    chk(tag, 64'(n), 64'(exp));
  endtask

  task automatic fetch_digest(int seed);
    for (int i = 0; i < 16; i++) core_dig_in[32*i +: 32] = 32'hD000_0000 + 32'(seed * 16 + i);
    pulse_get(); wait_idle(); tick(1);
  endtask

  // watchdog
  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    // R1 reset state
    chk("R1 rdy_in", rdy_in, 1); chk("R1 avail", avail, 0); chk("R1 out_full", out_full, 0);
    chk("R1 core_start", core_start, 0); chk("R1 core_dig_req", core_dig_req, 0);
    chk("R1 block", 64'(core_block != 0), 0); chk("R1 dig_rdata", dig_rdata, 0);
    tick(2); rst_n = 1; tick(1);

    // SHA-256 block, plus out-of-range write (R3)
    alg_sel = 2'd1;
    for (int i = 0; i < 16; i++) wr_din(i, 32'hA000_0000 + 32'(i));
    wr_din(20, 32'hBAD0_0020);
    chk("R3 out of range word", core_block[32*20 +: 32], 0);
    pulse_avail(0);
    chk("R4 rdy low when avail", rdy_in, 0);
    wr_din(3, 32'hBAD0_0003);
    chk("R3 write while pending", core_block[32*3 +: 32], 32'hA000_0003);
    wait_idle(); tick(1);
    chk("R5 buffer cleared", 64'(core_block != 0), 0);
    chk("R5 rdy after done", rdy_in, 1);

    // digest sizes per algorithm (R2, R7, R8)
    for (int a = 0; a < 4; a++) begin
      alg_sel = 2'(a);
      fetch_digest(a + 1);
      chk("R7 out_full set", out_full, 1);
      count_digest("R2 digest word count", dsz(2'(a)));
      pulse_clr(); tick(1);
      chk("R8 out_full cleared", out_full, 0);
    end

    // SHA-512 full block with pad
    alg_sel = 2'd3;
    for (int i = 0; i < 32; i++) wr_din(i, 32'hC000_0000 + 32'(i));
    chk("R2 block word 31", core_block[32*31 +: 32], 32'hC000_001F);
    pulse_avail(1);
    chk("R4 pad latched", core_pad, 1);
    wait_idle(); tick(1);

    // R6 hold-off while full
    fetch_digest(9);
    wr_din(0, 32'h1111_1111);
    chk("R6 write while full ignored", core_block[31:0], 0);
    started_seen = 0;
    pulse_avail(0); tick(5);
    chk("R6 no start while full", 64'(started_seen), 0);
    pulse_clr(); tick(3);
    chk("R6 start after release", 64'(started_seen), 1);
    wait_idle(); tick(1);

    // R11 get-digest while pending is ignored
    alg_sel = 2'd1;
    pulse_avail(0);
    pulse_get(); tick(1);
    chk("R11 no req while avail", core_dig_req, 0);
    wait_idle(); tick(1);

    // R9 restore intermediate digest
    alg_sel = 2'd3;
    for (int i = 0; i < 16; i++) wr_dig(i, 32'h5A00_0000 + 32'(i));
    chk("R9 chain word 15", core_chain[32*15 +: 32], 32'h5A00_000F);
    pulse_avail(0);
    wr_dig(2, 32'hBAD0_0002);
    chk("R9 write while pending ignored", core_chain[32*2 +: 32], 32'h5A00_0002);
    wait_idle(); tick(1);
    alg_sel = 2'd0;
    @(negedge clk); dig_ridx = 4'd7; #1;
    chk("R10 read beyond size", dig_rdata, 0);
    dig_ridx = 4'd6; #1;
    chk("R10 read in range", dig_rdata, 32'h5A00_0006);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule